// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Engine

This block is a small memory-to-memory mover that runs one service cycle every time its interrupt request input fires. A service cycle copies data from a source pointer to a destination pointer through a simple request/ready memory port. In single mode a cycle moves one item. In block mode a cycle moves a run of 1 to 32 items. An item is either a byte or a word, and the width is chosen at configuration time.

Each pointer has its own auto-increment option and its own update option. With update set, the pointer keeps the value it reached at the end of a cycle. With update clear, the pointer returns to the value it held when the cycle began. A cycle counter is decremented at the start of every cycle. When the counter reaches zero, the engine drops its own selection and pulses an end-of-service interrupt, so that the normal interrupt path can take over.

A global enable, set and cleared by dedicated command pulses, gates all service. A request that arrives while a cycle is running is held and served once that cycle ends.

Top module: `xfr_engine`

## Requirements
- R1: In single mode a service cycle performs exactly one read at `src_ptr` followed by one write at `dst_ptr` carrying the value read. `mem_word`=1 selects 16-bit items. `mem_word`=0 selects byte items, which use `mem_rdata[7:0]`, and the upper half of `mem_wdata` is driven to zero.
- R2: In block mode (`cfg_block`=1) a service cycle performs `cfg_blen_m1`+1 read/write pairs, from 1 to 32, alternating read then write.
- R3: The count register is decremented when a cycle starts. In the final phase of the cycle that leaves it at zero, `done_irq` is high for exactly one clock and `selected` clears. A loaded count of 0 therefore gives 256 cycles.
- R4: An auto-incrementing pointer advances after each completed write, by 1 for byte items and by 2 for word items. A pointer without auto-increment stays fixed.
- R5: At the end of a cycle, a pointer with update set keeps its final value. A pointer with update clear is restored to its value at the start of that cycle.
- R6: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ready` is seen. Each high `mem_ready` completes exactly one transfer.
- R7: A `cmd_enable` pulse sets `global_en` and a `cmd_disable` pulse clears it; if both arrive together, disable wins. A request that arrives while `global_en` or `selected` is low is not latched.
- R8: A request that arrives during a busy cycle is held. The next cycle starts after the current one ends, with no further request. Several requests during one busy cycle produce one extra cycle.
- R9: A request that lands in the final phase of the last cycle is discarded. A `cfg_load` while busy is ignored. An accepted `cfg_load` loads the pointers, count, mode and block length, and sets `selected`.
- R10: After reset the engine is idle, unselected and disabled, with `mem_req`, `done_irq` and `count_left` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_enable | input | 1 | Pulse: set global enable |
| cmd_disable | input | 1 | Pulse: clear global enable (wins) |
| cfg_load | input | 1 | Pulse: load configuration, accepted only when idle |
| cfg_src | input | ADDR_W | Source pointer start value |
| cfg_dst | input | ADDR_W | Destination pointer start value |
| cfg_count | input | COUNT_W | Cycle count, 0 means 2^COUNT_W |
| cfg_blen_m1 | input | BLK_W | Block length minus one |
| cfg_block | input | 1 | 1 = block mode, 0 = single mode |
| cfg_word | input | 1 | 1 = word items, 0 = byte items |
| cfg_src_inc | input | 1 | Source auto-increment |
| cfg_dst_inc | input | 1 | Destination auto-increment |
| cfg_src_upd | input | 1 | Source keeps final value |
| cfg_dst_upd | input | 1 | Destination keeps final value |
| irq_req | input | 1 | Service request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | Access width, 1 = word |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with ready |
| mem_ready | input | 1 | Access completes this clock |
| busy | output | 1 | A service cycle is running |
| selected | output | 1 | Engine owns its interrupt |
| global_en | output | 1 | Global enable state |
| done_irq | output | 1 | End-of-service pulse |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| count_left | output | COUNT_W | Remaining cycle count |

## Verification
The sharpest collision is between a new service request and the end of service. The request is provoked by driving `irq_req` in exactly the clock where `done_irq` is seen high. It is judged by reloading the engine and confirming that no cycle starts until a fresh request arrives. The other collision is a request, or a `cfg_load`, landing while a block cycle waits on a slow memory. There the bench checks that exactly one extra cycle follows and that the pointers and count were not reloaded. Around these cases, a sweep over every width, mode, increment and update combination at several memory latencies compares each write address and data item, and the pointer values after each cycle, against arithmetic expectations.

// File: rtl/xfr_pkg.sv
// Shared types for the transfer engine.
// Assumes: one sequencer state encoding and one packed mode record are used by all units.
package xfr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } xfr_state_e;

    typedef struct packed {
        logic block;
        logic word;
        logic src_inc;
        logic dst_inc;
        logic src_upd;
        logic dst_upd;
    } xfr_mode_t;

endpackage

// File: rtl/xfr_ptr_unit.sv
// One address pointer of the transfer engine.
// Function: holds the pointer, snapshots it at cycle start, advances it after
// each write when increment is on, and restores the snapshot at cycle end
// when update is off.
// Assumes: snap, advance and finish are never asserted in the same clock.
module xfr_ptr_unit #(
    parameter int ADDR_W     = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              snap,
    input  logic              advance,
    input  logic              finish,
    input  logic              word,
    input  logic              inc,
    input  logic              upd,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] saved_q;

    // Pointer register: load, advance, or restore at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (advance && inc) begin
            ptr_q <= ptr_q + (word ? STEP_WORD : STEP_BYTE);
        end else if (finish && !upd) begin
            ptr_q <= saved_q;
        end
    end

    // Start-of-cycle snapshot used for the restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= '0;
        end else if (snap) begin
            saved_q <= ptr_q;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/xfr_cycle_count.sv
// Service cycle counter.
// Function: loaded by configuration and decremented at each cycle start.
// It wraps at zero, so a loaded 0 gives 2^COUNT_W cycles.
// Assumes: load and dec are never asserted together.
module xfr_cycle_count #(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               dec,
    output logic [COUNT_W-1:0] count,
    output logic               zero
);

    logic [COUNT_W-1:0] cnt_q;

    // Count register: load or decrement with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - COUNT_W'(1);
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

endmodule

// File: rtl/xfr_seq.sv
// Sequencer of the transfer engine.
// Function: keeps the global enable, the selection and pending-request flags,
// runs the read/write phases of a service cycle over the memory port, and
// signals cycle start, pointer advance and cycle finish to the other units.
// Assumes: the mode and block length are stable during a cycle (the top loads
// them only when load_ok is high).
module xfr_seq
    import xfr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cfg_load,
    input  logic              irq_req,
    input  xfr_mode_t         mode,
    input  logic [BLK_W-1:0]  blen_m1,
    input  logic              count_zero,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              load_ok,
    output logic              start,
    output logic              advance,
    output logic              finish,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              selected,
    output logic              global_en,
    output logic              done_irq
);

    localparam int BYTE_W = 8;

    xfr_state_e        state_q;
    xfr_state_e        state_d;
    logic [BLK_W-1:0]  beat_q;
    logic [DATA_W-1:0] data_q;
    logic              pend_q;
    logic              sel_q;
    logic              gen_q;
    logic              take;
    logic              end_service;

    // Decode of the control strobes for this clock.
    always_comb begin
        load_ok     = cfg_load && (state_q == ST_IDLE);
        start       = (state_q == ST_IDLE) && pend_q && sel_q && gen_q && !cfg_load;
        advance     = (state_q == ST_WRITE) && mem_ready;
        finish      = (state_q == ST_FINISH);
        end_service = finish && count_zero;
        take        = irq_req && sel_q && gen_q;
    end

    // Next-state logic for the read/write phases.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_READ;
            ST_READ:   if (mem_ready) state_d = ST_WRITE;
            ST_WRITE:  if (mem_ready) state_d = (beat_q == '0) ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Beats left in the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (start) begin
            beat_q <= mode.block ? blen_m1 : '0;
        end else if (advance && (beat_q != '0)) begin
            beat_q <= beat_q - BLK_W'(1);
        end
    end

    // Data holding register between the read and the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if ((state_q == ST_READ) && mem_ready) begin
            data_q <= mode.word ? mem_rdata
                                : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
        end
    end

    // Pending request: set by an accepted request, cleared at start or end of service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (end_service) begin
            pend_q <= 1'b0;
        end else if (take) begin
            pend_q <= 1'b1;
        end else if (start) begin
            pend_q <= 1'b0;
        end
    end

    // Selection: set by an accepted load, dropped at end of service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (end_service) begin
            sel_q <= 1'b0;
        end else if (load_ok) begin
            sel_q <= 1'b1;
        end
    end

    // Global enable: the disable command wins over the enable command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= 1'b0;
        end else if (cmd_disable) begin
            gen_q <= 1'b0;
        end else if (cmd_enable) begin
            gen_q <= 1'b1;
        end
    end

    // Memory port and status outputs.
    always_comb begin
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = (state_q == ST_READ) ? src_ptr : dst_ptr;
        mem_wdata = data_q;
        busy      = (state_q != ST_IDLE);
        selected  = sel_q;
        global_en = gen_q;
        done_irq  = end_service;
    end

endmodule

// File: rtl/xfr_engine.sv
// Interrupt-triggered single/block transfer engine, top level.
// Function: holds the loaded mode and block length, and ties together the
// sequencer, the cycle counter and one pointer unit each for source and
// destination (built by a generate loop).
// Assumes: the memory port answers every request eventually; the
// configuration inputs are sampled only on an accepted cfg_load.
module xfr_engine
    import xfr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int COUNT_W = 8,
    parameter int BLK_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_enable,
    input  logic               cmd_disable,
    input  logic               cfg_load,
    input  logic [ADDR_W-1:0]  cfg_src,
    input  logic [ADDR_W-1:0]  cfg_dst,
    input  logic [COUNT_W-1:0] cfg_count,
    input  logic [BLK_W-1:0]   cfg_blen_m1,
    input  logic               cfg_block,
    input  logic               cfg_word,
    input  logic               cfg_src_inc,
    input  logic               cfg_dst_inc,
    input  logic               cfg_src_upd,
    input  logic               cfg_dst_upd,
    input  logic               irq_req,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_word,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    output logic               busy,
    output logic               selected,
    output logic               global_en,
    output logic               done_irq,
    output logic [ADDR_W-1:0]  src_ptr,
    output logic [ADDR_W-1:0]  dst_ptr,
    output logic [COUNT_W-1:0] count_left
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int NUM_PTR    = 2;

    xfr_mode_t         mode_q;
    logic [BLK_W-1:0]  blen_q;
    logic              load_ok;
    logic              start;
    logic              advance;
    logic              finish;
    logic              count_zero;
    logic [ADDR_W-1:0] ptr_init [NUM_PTR];
    logic [ADDR_W-1:0] ptr_val  [NUM_PTR];
    logic [NUM_PTR-1:0] ptr_inc;
    logic [NUM_PTR-1:0] ptr_upd;

    // Mode and block length registers, loaded with the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            blen_q <= '0;
        end else if (load_ok) begin
            mode_q <= '{block: cfg_block, word: cfg_word,
                        src_inc: cfg_src_inc, dst_inc: cfg_dst_inc,
                        src_upd: cfg_src_upd, dst_upd: cfg_dst_upd};
            blen_q <= cfg_blen_m1;
        end
    end

    assign ptr_init[0] = cfg_src;
    assign ptr_init[1] = cfg_dst;
    assign ptr_inc     = {mode_q.dst_inc, mode_q.src_inc};
    assign ptr_upd     = {mode_q.dst_upd, mode_q.src_upd};

    xfr_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BLK_W  (BLK_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_enable  (cmd_enable),
        .cmd_disable (cmd_disable),
        .cfg_load    (cfg_load),
        .irq_req     (irq_req),
        .mode        (mode_q),
        .blen_m1     (blen_q),
        .count_zero  (count_zero),
        .src_ptr     (ptr_val[0]),
        .dst_ptr     (ptr_val[1]),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .load_ok     (load_ok),
        .start       (start),
        .advance     (advance),
        .finish      (finish),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .selected    (selected),
        .global_en   (global_en),
        .done_irq    (done_irq)
    );

    xfr_cycle_count #(
        .COUNT_W (COUNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (cfg_count),
        .dec      (start),
        .count    (count_left),
        .zero     (count_zero)
    );

    generate
        for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
            xfr_ptr_unit #(
                .ADDR_W     (ADDR_W),
                .WORD_BYTES (WORD_BYTES)
            ) u_ptr (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load_ok),
                .load_val (ptr_init[i]),
                .snap     (start),
                .advance  (advance),
                .finish   (finish),
                .word     (mode_q.word),
                .inc      (ptr_inc[i]),
                .upd      (ptr_upd[i]),
                .ptr      (ptr_val[i])
            );
        end
    endgenerate

    assign src_ptr  = ptr_val[0];
    assign dst_ptr  = ptr_val[1];
    assign mem_word = mode_q.word;

endmodule

// File: rtl/xfr_engine_chk.sv
// Property checker for xfr_engine, attached by bind.
// Function: watches the top-level ports for protocol and sequencing rules.
// Assumes: synchronous active-low reset on rst_n.
module xfr_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_disable,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              busy,
    input logic              selected,
    input logic              global_en,
    input logic              done_irq
);

    // R3: end of service drops the selection.
    a_r3_done_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !selected);

    // R3: the end-of-service interrupt lasts one clock.
    a_r3_done_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R6: an unanswered request holds its address and direction.
    a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: an unanswered write holds its data.
    a_r6_hold_wdata: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ready) |=> $stable(mem_wdata));

    // R7: a disable command always leaves the engine disabled.
    a_r7_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> !global_en);

    // R7: a cycle only starts when enabled and selected.
    a_r7_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(global_en) && $past(selected)));

    // R1: memory is only touched inside a service cycle.
    a_r1_req_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

bind xfr_engine xfr_engine_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_disable (cmd_disable),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .busy        (busy),
    .selected    (selected),
    .global_en   (global_en),
    .done_irq    (done_irq)
);

// File: tb/xfr_engine_test.sv
`timescale 1ns/1ps
module xfr_engine_test;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int BW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_enable = 1'b0;
    logic          cmd_disable = 1'b0;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [BW-1:0] cfg_blen_m1 = '0;
    logic          cfg_block = 1'b0;
    logic          cfg_word = 1'b0;
    logic          cfg_src_inc = 1'b0;
    logic          cfg_dst_inc = 1'b0;
    logic          cfg_src_upd = 1'b0;
    logic          cfg_dst_upd = 1'b0;
    logic          irq_req = 1'b0;
    logic          mem_req;
    logic          mem_we;
    logic          mem_word;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          busy;
    logic          selected;
    logic          global_en;
    logic          done_irq;
    logic [AW-1:0] src_ptr;
    logic [AW-1:0] dst_ptr;
    logic [CW-1:0] count_left;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [256];
    int          lat = 0;
    int          wait_cnt = 0;
    int          wr_n = 0;
    logic [AW-1:0] wr_addr [64];
    logic [DW-1:0] wr_data [64];
    int          req_seen = 0;
    int          done_cnt = 0;

    always #4 clk = ~clk;

    xfr_engine #(.ADDR_W(AW), .DATA_W(DW), .COUNT_W(CW), .BLK_W(BW)) uut (.*);

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7) + 3);
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Memory responder with programmable latency, write log, done counter.
    initial begin
        forever begin
            @(negedge clk);
            if (done_irq) done_cnt++;
            if (mem_req) begin
                if (mem_ready) req_seen = req_seen;
                if (wait_cnt >= lat) begin
                    mem_ready = 1'b1;
                    wait_cnt = 0;
                    req_seen++;
                    if (mem_we) begin
                        mem[mem_addr[7:0]] = mem_wdata[7:0];
                        if (mem_word) mem[8'(mem_addr[7:0] + 8'd1)] = mem_wdata[15:8];
                        if (wr_n < 64) begin
                            wr_addr[wr_n] = mem_addr;
                            wr_data[wr_n] = mem_wdata;
                        end
                        wr_n++;
                    end else begin
                        mem_rdata = {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
                    end
                end else begin
                    mem_ready = 1'b0;
                    wait_cnt++;
                end
            end else begin
                mem_ready = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    task automatic load_cfg(input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input logic [CW-1:0] c, input logic [BW-1:0] bl,
                            input logic [5:0] m);
        @(negedge clk);
        cfg_src = s; cfg_dst = d; cfg_count = c; cfg_blen_m1 = bl;
        {cfg_dst_upd, cfg_src_upd, cfg_dst_inc, cfg_src_inc, cfg_block, cfg_word} = m;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk);
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic wait_cycle();
        int n = 0;
        while (!busy && n < 50) begin @(negedge clk); n++; end
        if (!busy) check_eq("R1", "cycle start", 0, 1);
        n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = pat(a);
        repeat (3) @(negedge clk);
        // R10: reset state
        check_eq("R10", "busy", busy, 0);
        check_eq("R10", "selected", selected, 0);
        check_eq("R10", "global_en", global_en, 0);
        check_eq("R10", "mem_req", mem_req, 0);
        check_eq("R10", "done_irq", done_irq, 0);
        check_eq("R10", "count_left", count_left, 0);
        rst_n = 1'b1;

        // R7: requests while disabled are not latched
        load_cfg(16'h0010, 16'h0080, 8'd4, 5'd0, 6'b000000);
        fire();
        repeat (6) @(negedge clk);
        check_eq("R7", "no cycle while disabled", busy | (req_seen != 0), 0);
        @(negedge clk); cmd_enable = 1'b1; @(negedge clk); cmd_enable = 1'b0;
        check_eq("R7", "enable sets", global_en, 1);
        repeat (6) @(negedge clk);
        check_eq("R7", "disabled request not latched", req_seen, 0);
        @(negedge clk); cmd_enable = 1'b1; cmd_disable = 1'b1;
        @(negedge clk); cmd_enable = 1'b0; cmd_disable = 1'b0;
        check_eq("R7", "disable wins", global_en, 0);
        @(negedge clk); cmd_enable = 1'b1; @(negedge clk); cmd_enable = 1'b0;

        // R1 R2 R4 R5 R3: sweep of every mode combination
        for (int cfg = 0; cfg < 64; cfg++) begin
            logic wd, bk, si, di, su, du;
            logic [AW-1:0] es, ed;
            int nb, st;
            wd = cfg[0]; bk = cfg[1]; si = cfg[2]; di = cfg[3]; su = cfg[4]; du = cfg[5];
            lat = cfg % 3;
            for (int a = 0; a < 256; a++) mem[a] = pat(a);
            load_cfg(16'h0010, 16'h0080, 8'd2, 5'd2, 6'(cfg));
            es = 16'h0010; ed = 16'h0080;
            nb = bk ? 3 : 1;
            st = wd ? 2 : 1;
            for (int k = 0; k < 2; k++) begin
                int d0;
                d0 = done_cnt;
                wr_n = 0;
                fire();
                wait_cycle();
                check_eq(bk ? "R2" : "R1", "writes per cycle", wr_n, nb);
                for (int b = 0; b < nb && b < wr_n; b++) begin
                    logic [AW-1:0] ra, wa;
                    logic [DW-1:0] ev;
                    ra = es + (si ? AW'(b * st) : '0);
                    wa = ed + (di ? AW'(b * st) : '0);
                    ev = wd ? {pat(int'(ra) + 1), pat(int'(ra))} : {8'h00, pat(int'(ra))};
                    check_eq("R4", "write address", wr_addr[b], wa);
                    check_eq("R1", "write data", wr_data[b], ev);
                end
                if (si && su) es = es + AW'(nb * st);
                if (di && du) ed = ed + AW'(nb * st);
                check_eq("R5", "src_ptr after cycle", src_ptr, es);
                check_eq("R5", "dst_ptr after cycle", dst_ptr, ed);
                check_eq("R3", "count_left", count_left, 1 - k);
                check_eq("R3", "done pulses", done_cnt - d0, k);
                check_eq("R3", "selected", selected, k == 0);
            end
        end

        // R8 R9: pending requests and load while busy
        lat = 2;
        load_cfg(16'h0020, 16'h00A0, 8'd3, 5'd3, 6'b000010);
        fire();
        while (!busy) @(negedge clk);
        fire();
        fire();
        @(negedge clk);
        cfg_src = 16'h0055; cfg_count = 8'd9; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        wait_cycle();
        wait_cycle();
        repeat (12) @(negedge clk);
        check_eq("R8", "one extra cycle from pending", count_left, 1);
        check_eq("R8", "engine idle after pending", busy, 0);
        check_eq("R9", "load while busy ignored", src_ptr, 16'h0020);

        // R9: request in the final phase of the last cycle is discarded
        lat = 0;
        load_cfg(16'h0010, 16'h0080, 8'd1, 5'd0, 6'b000000);
        fire();
        begin
            int n = 0;
            while (!done_irq && n < 100) begin @(negedge clk); n++; end
        end
        check_eq("R3", "done seen on last cycle", done_irq, 1);
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        check_eq("R3", "selected cleared", selected, 0);
        load_cfg(16'h0010, 16'h0080, 8'd1, 5'd0, 6'b000000);
        begin
            int r0;
            r0 = req_seen;
            repeat (8) @(negedge clk);
            check_eq("R9", "late request discarded", req_seen - r0, 0);
        end
        fire();
        wait_cycle();
        check_eq("R9", "fresh request served", count_left, 0);

        // R3: loaded count 0 gives 256 cycles
        load_cfg(16'h0010, 16'h0080, 8'd0, 5'd0, 6'b000000);
        begin
            int d0;
            d0 = done_cnt;
            for (int k = 0; k < 255; k++) begin
                fire();
                wait_cycle();
            end
            check_eq("R3", "no done before 256th", done_cnt - d0, 0);
            check_eq("R3", "count before 256th", count_left, 1);
            check_eq("R3", "still selected", selected, 1);
            fire();
            wait_cycle();
            check_eq("R3", "done on 256th", done_cnt - d0, 1);
            check_eq("R3", "unselected after 256th", selected, 0);
        end

        finish_sim();
    end

endmodule